// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block sits beside a small 8-bit processor core and decides which of six interrupt sources the core should service next. Every source carries two priority bits that place it on one of four levels. The block remembers which levels are currently being serviced, so a higher-level request can interrupt a lower-level handler. When that handler returns, the interrupted one continues. Within one level, a fixed scan order settles ties.

The core sees a request flag, a vector address and the granted level. It answers with a one-cycle acknowledge, and with a one-cycle return strobe when a handler ends. The request/acknowledge pair works like a valid/ready handshake. `irq_req` is the valid. `irq_vector` and `irq_level` are meaningful only while it is high. An acknowledge counts only in a cycle where `irq_req` is high, and there is no other back-pressure. Software programs the controller through a write-only port: address, data and write strobe. The port reaches four registers: source enables, low priority bits, high priority bits, and the detection mode of the two external pins. Timer flags arrive as one-cycle pulses. The serial and timer-2 flags arrive as levels that their own peripherals clear.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, all registers and the in-service mask are zero and `irq_req` is low.
- R2: Sources are scanned in this order, with index 0 first: external 0, timer 0, external 1, timer 1, serial, timer 2. The vector of source index i is 03h + 8·i, giving 03h, 0Bh, 13h, 1Bh, 23h and 2Bh.
- R3: Register 0 holds the enables. Bit 7 is the global enable and bit 6 is unused. Bits 0..5 enable the source with the same index. A source requests only when its own bit and bit 7 are both 1.
- R4: Register 1 holds the low priority bit and register 2 the high priority bit, one bit per source index. The level is {high, low}, and 3 is the highest. The pending source with the highest level wins, whatever its index.
- R5: Among pending sources of the same level, the lowest index wins.
- R6: `irq_req` is raised only when the winner's level is above every level in the in-service mask. A request at an equal or lower level waits.
- R7: An acknowledge while `irq_req` is high sets the in-service bit of the granted level at the next cycle. An acknowledge while `irq_req` is low changes nothing.
- R8: A return strobe clears the highest set in-service bit, so a preempted lower-level handler, or a waiting request, becomes current again. A return strobe with an empty mask does nothing.
- R9: Register 3 bit 0 selects the mode for external 0 and bit 1 the mode for external 1 (1 = falling edge, 0 = low level). In edge mode a falling edge latches a flag, and an acknowledge of that source clears it. In level mode the request follows the low pin and an acknowledge never clears it.
- R10: A timer 0 or timer 1 pulse latches a flag, and an acknowledge of that source clears it. If a pulse arrives in the cycle of the acknowledge, the flag stays set.
- R11: The serial and timer-2 request inputs are never cleared by the block. They request for as long as they stay high.
- R12: When an acknowledge and a return strobe fall in the same cycle, the highest previously set bit is cleared and the newly granted level's bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 enable, 1 prio low, 2 prio high, 3 mode) |
| reg_wr_data | input | 8 | Register write data |
| ext_n | input | 2 | External interrupt pins, active low |
| tmr0_pulse | input | 1 | Timer 0 overflow pulse |
| tmr1_pulse | input | 1 | Timer 1 overflow pulse |
| ser_req | input | 1 | Serial request level, cleared by software |
| tmr2_req | input | 1 | Timer 2 request level, cleared by software |
| irq_ack | input | 1 | Core acknowledge pulse |
| irq_reti | input | 1 | Core return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to core (valid) |
| irq_vector | output | 8 | Vector of the winning source |
| irq_level | output | 2 | Level of the winning source |
| in_service | output | 4 | In-service mask, one bit per level |

## Verification
Two pairs of events can land on the same clock edge. The first pair is an acknowledge and a return strobe. The bench drives both in one cycle while a level-0 handler is active and a level-2 request is presented. It then expects the mask to show only the level-2 bit. The second pair is an acknowledge of timer 0 and a fresh timer 0 pulse. The bench drives both together, and after the next return it expects the timer-0 request to be presented again with vector 0Bh.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int NUM_SRC = 6;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int NUM_EXT = 2;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [IDX_W-1:0] {
    SRC_X0 = 3'd0,
    SRC_T0 = 3'd1,
    SRC_X1 = 3'd2,
    SRC_T1 = 3'd3,
    SRC_SP = 3'd4,
    SRC_T2 = 3'd5
  } src_e;

  typedef enum logic [1:0] {
    RA_ENABLE = 2'd0,
    RA_PRIO_L = 2'd1,
    RA_PRIO_H = 2'd2,
    RA_MODE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/nic_regs.sv
module nic_regs
  import nic_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      en_q,
  output logic [NUM_SRC-1:0] plo_q,
  output logic [NUM_SRC-1:0] phi_q,
  output logic [NUM_EXT-1:0] mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      plo_q  <= '0;
      phi_q  <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        RA_ENABLE: en_q   <= wdata;
        RA_PRIO_L: plo_q  <= wdata[NUM_SRC-1:0];
        RA_PRIO_H: phi_q  <= wdata[NUM_SRC-1:0];
        RA_MODE:   mode_q <= wdata[NUM_EXT-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nic_ext_det.sv
module nic_ext_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic prev_q;
  logic flag_q;
  logic fell;

  assign fell = prev_q & ~pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_n;
      flag_q <= edge_mode ? ((flag_q & ~clr) | fell) : 1'b0;
    end
  end

  assign req = edge_mode ? flag_q : ~pin_n;
endmodule

// File: rtl/nic_pick.sv
module nic_pick
  import nic_pkg::*;
(
  input  logic [NUM_SRC-1:0]       pend,
  input  lvl_t [NUM_SRC-1:0]       src_lvl,
  input  logic [NUM_LVL-1:0]       active,
  output logic                     take,
  output logic [IDX_W-1:0]         win_idx,
  output lvl_t                     win_lvl
);
  logic found;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (!found && pend[s] && src_lvl[s] == LVL_W'(l)) begin
          found   = 1'b1;
          win_idx = IDX_W'(s);
          win_lvl = LVL_W'(l);
        end
      end
    end
  end

  assign take = found && ((active >> win_lvl) == '0);
endmodule

// File: rtl/nic_svc.sv
module nic_svc
  import nic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grant,
  input  lvl_t               grant_lvl,
  input  logic               reti,
  output logic [NUM_LVL-1:0] active
);
  logic [NUM_LVL-1:0] top_bit;
  logic [NUM_LVL-1:0] nxt;

  always_comb begin
    top_bit = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (active[l]) top_bit = NUM_LVL'(1) << l;
    end
    nxt = active;
    if (reti)  nxt = nxt & ~top_bit;
    if (grant) nxt = nxt | (NUM_LVL'(1) << grant_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= '0;
    else        active <= nxt;
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h03,
  parameter logic [VEC_W-1:0] VEC_STEP = 8'h08
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_addr,
  input  logic [7:0]         reg_wr_data,
  input  logic [1:0]         ext_n,
  input  logic               tmr0_pulse,
  input  logic               tmr1_pulse,
  input  logic               ser_req,
  input  logic               tmr2_req,
  input  logic               irq_ack,
  input  logic               irq_reti,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vector,
  output logic [1:0]         irq_level,
  output logic [3:0]         in_service
);
  localparam int DW = 8;

  logic [DW-1:0]      en_q;
  logic [NUM_SRC-1:0] plo_q, phi_q;
  logic [NUM_EXT-1:0] mode_q;
  logic [NUM_EXT-1:0] ext_req;
  logic [NUM_EXT-1:0] ext_clr;
  logic [1:0]         tmr_flag_q;
  logic [1:0]         tmr_set;
  logic [1:0]         tmr_clr;
  logic [NUM_SRC-1:0] raw, pend;
  lvl_t [NUM_SRC-1:0] src_lvl;
  logic               take;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;
  logic               grant;

  nic_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wr_data), .en_q(en_q), .plo_q(plo_q), .phi_q(phi_q),
    .mode_q(mode_q)
  );

  assign grant = irq_ack & take;

  assign ext_clr[0] = grant && (win_idx == SRC_X0);
  assign ext_clr[1] = grant && (win_idx == SRC_X1);

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    nic_ext_det u_det (
      .clk(clk), .rst_n(rst_n), .pin_n(ext_n[e]), .edge_mode(mode_q[e]),
      .clr(ext_clr[e]), .req(ext_req[e])
    );
  end

  assign tmr_set    = {tmr1_pulse, tmr0_pulse};
  assign tmr_clr[0] = grant && (win_idx == SRC_T0);
  assign tmr_clr[1] = grant && (win_idx == SRC_T1);

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmr_flag_q[t] <= 1'b0;
      else        tmr_flag_q[t] <= (tmr_flag_q[t] & ~tmr_clr[t]) | tmr_set[t];
    end
  end

  assign raw = {tmr2_req, ser_req, tmr_flag_q[1], ext_req[1], tmr_flag_q[0], ext_req[0]};
  assign pend = raw & en_q[NUM_SRC-1:0] & {NUM_SRC{en_q[DW-1]}};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
    assign src_lvl[s] = {phi_q[s], plo_q[s]};
  end

  nic_pick u_pick (
    .pend(pend), .src_lvl(src_lvl), .active(in_service),
    .take(take), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  nic_svc u_svc (
    .clk(clk), .rst_n(rst_n), .grant(grant), .grant_lvl(win_lvl),
    .reti(irq_reti), .active(in_service)
  );

  assign irq_req    = take;
  assign irq_level  = win_lvl;
  assign irq_vector = VEC_BASE + VEC_STEP * VEC_W'(win_idx);
endmodule

module nic_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_en,
  input logic       irq_req,
  input logic       irq_ack,
  input logic       irq_reti,
  input logic [1:0] irq_level,
  input logic [7:0] irq_vector,
  input logic [3:0] in_service,
  input logic [7:0] en_q
);
  p_vec_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector[2:0] == 3'd3 && irq_vector <= 8'h2B));

  p_global_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[7] |-> !irq_req);

  p_en_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(en_q));

  p_above_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((in_service >> irq_level) == 4'd0));

  p_ack_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> in_service[$past(irq_level)]);

  p_ack_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && !irq_reti) |=> $stable(in_service));

  p_reti_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_reti && !(irq_ack && irq_req) && in_service != 4'd0) |=>
      ($countones(in_service) == $countones($past(in_service)) - 1));
endmodule

bind nest_irq_ctrl nic_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .irq_req(irq_req),
  .irq_ack(irq_ack), .irq_reti(irq_reti), .irq_level(irq_level),
  .irq_vector(irq_vector), .in_service(in_service), .en_q(en_q)
);

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wr_data = '0;
  logic [1:0] ext_n = 2'b11;
  logic       tmr0_pulse = 1'b0, tmr1_pulse = 1'b0;
  logic       ser_req = 1'b0, tmr2_req = 1'b0;
  logic       irq_ack = 1'b0, irq_reti = 1'b0;
  logic       irq_req;
  logic [7:0] irq_vector;
  logic [1:0] irq_level;
  logic [3:0] in_service;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       ev_ack;

  always #(CLK_P/2) clk = ~clk;

  nest_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .ext_n(ext_n), .tmr0_pulse(tmr0_pulse),
    .tmr1_pulse(tmr1_pulse), .ser_req(ser_req), .tmr2_req(tmr2_req),
    .irq_ack(irq_ack), .irq_reti(irq_reti), .irq_req(irq_req),
    .irq_vector(irq_vector), .irq_level(irq_level), .in_service(in_service)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected grants as the design presents them
  always begin
    @(ev_ack);
    if (exp_q.size() == 0) chk("R7 unexpected grant", 32'd1, 32'd0);
    else begin
      string t = tag_q.pop_front();
      chk(t, {31'd0, irq_req}, 32'd1);
      chk(t, {24'd0, irq_vector}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    tick();
    reg_wr_en = 1'b0;
  endtask

  task automatic ack_expect(input logic [7:0] vec, input string tag, input logic with_reti);
    exp_q.push_back(vec);
    tag_q.push_back(tag);
    irq_ack = 1'b1; irq_reti = with_reti;
    #1 -> ev_ack;
    tick();
    irq_ack = 1'b0; irq_reti = 1'b0;
  endtask

  task automatic reti();
    irq_reti = 1'b1;
    tick();
    irq_reti = 1'b0;
  endtask

  task automatic pulse0();
    tmr0_pulse = 1'b1;
    tick();
    tmr0_pulse = 1'b0;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    #1;
    chk("R1 reset req", {31'd0, irq_req}, 32'd0);
    chk("R1 reset in_service", {28'd0, in_service}, 32'd0);
    rst_n = 1'b1;
    tick();

    // R3 masking
    wr(2'd0, 8'h3F);
    pulse0();
    #1 chk("R3 global off", {31'd0, irq_req}, 32'd0);
    wr(2'd0, 8'hBD);
    #1 chk("R3 source off", {31'd0, irq_req}, 32'd0);
    wr(2'd0, 8'hBF);
    #1 chk("R3 enabled req", {31'd0, irq_req}, 32'd1);
    chk("R2 timer0 vector", {24'd0, irq_vector}, 32'h0B);
    ack_expect(8'h0B, "R7 grant t0", 1'b0);
    chk("R7 in_service lvl0", {28'd0, in_service}, 32'h1);
    chk("R10 t0 cleared", {31'd0, irq_req}, 32'd0);
    reti();
    chk("R8 empty", {28'd0, in_service}, 32'h0);

    // R5 same-level order, R6 equal waits, R8 resume
    tmr0_pulse = 1'b1; tmr1_pulse = 1'b1;
    tick();
    tmr0_pulse = 1'b0; tmr1_pulse = 1'b0;
    #1 chk("R5 poll order", {24'd0, irq_vector}, 32'h0B);
    ack_expect(8'h0B, "R5 grant t0", 1'b0);
    chk("R6 equal waits", {31'd0, irq_req}, 32'd0);
    reti();
    chk("R8 waiting now req", {31'd0, irq_req}, 32'd1);
    chk("R2 timer1 vector", {24'd0, irq_vector}, 32'h1B);
    ack_expect(8'h1B, "R8 grant t1", 1'b0);
    reti();

    // R4 level order, preemption, R11 persistent
    wr(2'd2, 8'h10);
    pulse0();
    ser_req = 1'b1;
    #1 chk("R4 higher level wins", {24'd0, irq_vector}, 32'h23);
    chk("R4 level value", {30'd0, irq_level}, 32'd2);
    ack_expect(8'h23, "R4 grant serial", 1'b0);
    chk("R6 lower waits", {31'd0, irq_req}, 32'd0);
    wr(2'd1, 8'h20);
    wr(2'd2, 8'h30);
    tmr2_req = 1'b1;
    #1 chk("R6 preempt req", {31'd0, irq_req}, 32'd1);
    ack_expect(8'h2B, "R4 grant t2", 1'b0);
    chk("R7 nested mask", {28'd0, in_service}, 32'hC);
    reti();
    chk("R8 highest cleared", {28'd0, in_service}, 32'h4);
    chk("R11 t2 persists", {24'd0, irq_vector}, 32'h2B);
    chk("R11 t2 req", {31'd0, irq_req}, 32'd1);
    tmr2_req = 1'b0;
    #1 chk("R11 t2 dropped", {31'd0, irq_req}, 32'd0);
    reti();
    chk("R11 serial persists", {24'd0, irq_vector}, 32'h23);
    ser_req = 1'b0;
    #1 chk("R8 lower resumes", {24'd0, irq_vector}, 32'h0B);
    ack_expect(8'h0B, "R8 grant t0", 1'b0);
    reti();
    chk("R8 all retired", {28'd0, in_service}, 32'h0);
    wr(2'd1, 8'h00);

    // R12 ack and reti together
    wr(2'd2, 8'h10);
    pulse0();
    ack_expect(8'h0B, "R12 setup", 1'b0);
    ser_req = 1'b1;
    #1;
    ack_expect(8'h23, "R12 grant", 1'b1);
    chk("R12 mask swap", {28'd0, in_service}, 32'h4);
    ser_req = 1'b0;
    reti();
    wr(2'd2, 8'h00);

    // R9 edge mode on ext 0
    wr(2'd3, 8'h01);
    ext_n[0] = 1'b0;
    #1 chk("R9 edge not yet", {31'd0, irq_req}, 32'd0);
    tick();
    chk("R9 edge latched", {24'd0, irq_vector}, 32'h03);
    ack_expect(8'h03, "R9 grant x0", 1'b0);
    reti();
    chk("R9 edge cleared", {31'd0, irq_req}, 32'd0);
    ext_n[0] = 1'b1;
    tick();

    // R9 level mode on ext 1
    ext_n[1] = 1'b0;
    #1 chk("R9 level req", {24'd0, irq_vector}, 32'h13);
    ack_expect(8'h13, "R9 grant x1", 1'b0);
    reti();
    chk("R9 level not cleared", {31'd0, irq_req}, 32'd1);
    ext_n[1] = 1'b1;
    #1 chk("R9 level released", {31'd0, irq_req}, 32'd0);

    // R7 stray ack, R8 stray reti
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    chk("R7 stray ack", {28'd0, in_service}, 32'h0);
    reti();
    chk("R8 stray reti", {28'd0, in_service}, 32'h0);

    // R10 pulse in ack cycle
    pulse0();
    tmr0_pulse = 1'b1;
    ack_expect(8'h0B, "R10 grant", 1'b0);
    tmr0_pulse = 1'b0;
    reti();
    chk("R10 set wins", {24'd0, irq_vector}, 32'h0B);
    chk("R10 set wins req", {31'd0, irq_req}, 32'd1);
    ack_expect(8'h0B, "R10 regrant", 1'b0);
    reti();
    chk("R10 finally cleared", {31'd0, irq_req}, 32'd0);

    tick();
    summary();
  end
endmodule